// File: doc/BRIEF.md
# Dual-Clock 36-bit FIFO with Reset-Selected Thresholds

This block is a 64-entry, 36-bit first-in first-out buffer that joins two unrelated clock domains. A producer on the port-A clock pushes words in. A consumer on the port-B clock pulls them into a registered output. Each port has a four-signal access qualifier: an active-low select, a direction bit, an enable and a mailbox-select line. The mailbox-select line must be low for a FIFO access. Each port also drives an output-enable signal. That signal stands in for the data pads, which would otherwise be high impedance.

Four active-low status flags guard the buffer. Full and almost-full belong to the write clock. Empty and almost-empty belong to the read clock. Both threshold flags use one offset. That offset is taken from a two-bit select input at the moment reset is released, and it stays fixed until the next reset. Reset is asynchronous and active low. Each clock domain brings its own side out of reset through a two-edge release chain.

Top module: `dcfifo36`

## Requirements
- R1: While `rst_n` is low, `full_n`=0, `empty_n`=0, `aempty_n`=0, `afull_n`=1, `b_dout`=0, and both pointers are cleared.
- R2: After `rst_n` rises, `full_n` is still 0 following the first rising edge of `clka` and becomes 1 following the second.
- R3: On the rising edge of `rst_n` the offset X is loaded from `fs`: 2'b00 gives 4, 2'b01 gives 8, 2'b10 gives 12, 2'b11 gives 16. Later changes of `fs` have no effect until the next reset.
- R4: A word is stored on a rising `clka` edge only when `a_cs_n`=0, `a_wr`=1, `a_en`=1, `a_mbox`=0 and `full_n`=1. Any other combination leaves the buffer unchanged.
- R5: A word moves into `b_dout` on a rising `clkb` edge only when `b_cs_n`=0, `b_wr`=0, `b_en`=1, `b_mbox`=0 and `empty_n`=1. Otherwise `b_dout` holds.
- R6: `a_oe` is 1 exactly when `a_cs_n`=0 and `a_wr`=0. `b_oe` is 1 exactly when `b_cs_n`=0 and `b_wr`=0.
- R7: `full_n` is 0 while the write side sees 64 words held, and writes attempted then are dropped.
- R8: `empty_n` is 0 while the read side sees no words. After a write into an empty buffer, it rises following the second `clkb` rising edge after the write edge.
- R9: `aempty_n` is 0 while the read side sees X words or fewer.
- R10: `afull_n` is 0 while the write side sees 64 minus X words or more.
- R11: Words leave in the order they were written, with their data unaltered.
- R12: Read attempts while `empty_n`=0 leave `b_dout` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clka | input | 1 | Write-side clock |
| clkb | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fs | input | 2 | Threshold offset select, sampled when reset releases |
| a_cs_n | input | 1 | Port-A select, active low |
| a_wr | input | 1 | Port-A direction: 1 write, 0 read |
| a_en | input | 1 | Port-A enable |
| a_mbox | input | 1 | Port-A mailbox select; must be 0 for FIFO writes |
| a_din | input | 36 | Write data |
| a_oe | output | 1 | Port-A pad output enable |
| full_n | output | 1 | Full flag, active low |
| afull_n | output | 1 | Almost-full flag, active low |
| b_cs_n | input | 1 | Port-B select, active low |
| b_wr | input | 1 | Port-B direction: 1 write, 0 read |
| b_en | input | 1 | Port-B enable |
| b_mbox | input | 1 | Port-B mailbox select; must be 0 for FIFO reads |
| b_dout | output | 36 | Registered read data |
| b_oe | output | 1 | Port-B pad output enable |
| empty_n | output | 1 | Empty flag, active low |
| aempty_n | output | 1 | Almost-empty flag, active low |

## Verification
The bench goes after the edges of each threshold for all four offset codes: exactly X words against X+1, and 63−X words against 64−X. A design with a mis-decoded select, or one that compares with < where it needs <=, moves the flag by one word. The bench also counts the edges of flag release after reset and after the first write. A missing or extra synchronizer stage shifts `full_n` or `empty_n` by one clock. Each single qualifier violation is tried on both ports, along with writes into a full buffer and reads from an empty one. A design that ignores the mailbox line, or that does not gate on a flag, stores or emits a word the reference model does not expect. The offset select is changed after release to catch a design that samples it continuously.

// File: rtl/dcf_pkg.sv
package dcf_pkg;

  localparam int PTR_MAX = 16;
  typedef logic [PTR_MAX-1:0] ptr_t;

  typedef struct packed {
    logic cs_n;
    logic wr;
    logic en;
    logic mbox;
  } port_ctl_t;

  function automatic ptr_t bin2gray(ptr_t b);
    return b ^ (b >> 1);
  endfunction

  function automatic ptr_t gray2bin(ptr_t g);
    ptr_t b;
    b = g;
    for (int i = 1; i < PTR_MAX; i++) b = b ^ (g >> i);
    return b;
  endfunction

  // offset selected at reset release: 4, 8, 12 or 16 words
  function automatic ptr_t thresh_for(logic [1:0] sel);
    return (ptr_t'(sel) + ptr_t'(1)) << 2;
  endfunction

  function automatic logic write_req(port_ctl_t c);
    return !c.cs_n && c.wr && c.en && !c.mbox;
  endfunction

  function automatic logic read_req(port_ctl_t c);
    return !c.cs_n && !c.wr && c.en && !c.mbox;
  endfunction

  function automatic logic drive_out(port_ctl_t c);
    return !c.cs_n && !c.wr;
  endfunction

endpackage

// File: rtl/dcf_sync.sv
module dcf_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/dcf_mem.sv
module dcf_mem #(
  parameter int DW = 36,
  parameter int AW = 6
) (
  input  logic          clka,
  input  logic          clkb,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] store [DEPTH];

  always_ff @(posedge clka) begin
    if (we) store[waddr] <= wdata;
  end

  always_ff @(posedge clkb or negedge rst_n) begin
    if (!rst_n)  rdata <= '0;
    else if (re) rdata <= store[raddr];
  end

endmodule

// File: rtl/dcf_wr_side.sv
module dcf_wr_side #(
  parameter int AW = 6,
  localparam int PW = AW + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ok,
  input  logic [PW-1:0]      x,
  input  dcf_pkg::port_ctl_t ctl,
  input  logic [PW-1:0]      rgray_s,
  output logic [PW-1:0]      wbin,
  output logic [PW-1:0]      wgray,
  output logic [PW-1:0]      level,
  output logic               full_n,
  output logic               afull_n,
  output logic               we
);

  localparam logic [PW-1:0] DEPTH_P = PW'(1 << AW);

  logic [PW-1:0] rbin_s;
  logic [PW-1:0] wbin_nx;

  always_comb begin
    rbin_s  = PW'(dcf_pkg::gray2bin(dcf_pkg::ptr_t'(rgray_s)));
    level   = wbin - rbin_s;
    full_n  = ok && (level != DEPTH_P);
    afull_n = !ok || (level < (DEPTH_P - x));
    we      = dcf_pkg::write_req(ctl) && full_n;
    wbin_nx = wbin + PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wbin  <= '0;
      wgray <= '0;
    end else if (we) begin
      wbin  <= wbin_nx;
      wgray <= PW'(dcf_pkg::bin2gray(dcf_pkg::ptr_t'(wbin_nx)));
    end
  end

endmodule

// File: rtl/dcf_rd_side.sv
module dcf_rd_side #(
  parameter int AW = 6,
  localparam int PW = AW + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ok,
  input  logic [PW-1:0]      x,
  input  dcf_pkg::port_ctl_t ctl,
  input  logic [PW-1:0]      wgray_s,
  output logic [PW-1:0]      rbin,
  output logic [PW-1:0]      rgray,
  output logic               empty_n,
  output logic               aempty_n,
  output logic               re
);

  logic [PW-1:0] wbin_s;
  logic [PW-1:0] level;
  logic [PW-1:0] rbin_nx;

  always_comb begin
    wbin_s   = PW'(dcf_pkg::gray2bin(dcf_pkg::ptr_t'(wgray_s)));
    level    = wbin_s - rbin;
    empty_n  = ok && (level != '0);
    aempty_n = ok && (level > x);
    re       = dcf_pkg::read_req(ctl) && empty_n;
    rbin_nx  = rbin + PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rbin  <= '0;
      rgray <= '0;
    end else if (re) begin
      rbin  <= rbin_nx;
      rgray <= PW'(dcf_pkg::bin2gray(dcf_pkg::ptr_t'(rbin_nx)));
    end
  end

endmodule

// File: rtl/dcfifo36.sv
module dcfifo36 #(
  parameter int DW          = 36,
  parameter int AW          = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clka,
  input  logic          clkb,
  input  logic          rst_n,
  input  logic [1:0]    fs,
  input  logic          a_cs_n,
  input  logic          a_wr,
  input  logic          a_en,
  input  logic          a_mbox,
  input  logic [DW-1:0] a_din,
  output logic          a_oe,
  output logic          full_n,
  output logic          afull_n,
  input  logic          b_cs_n,
  input  logic          b_wr,
  input  logic          b_en,
  input  logic          b_mbox,
  output logic [DW-1:0] b_dout,
  output logic          b_oe,
  output logic          empty_n,
  output logic          aempty_n
);

  localparam int PW = AW + 1;

  dcf_pkg::port_ctl_t ctl_a, ctl_b;
  assign ctl_a = '{cs_n: a_cs_n, wr: a_wr, en: a_en, mbox: a_mbox};
  assign ctl_b = '{cs_n: b_cs_n, wr: b_wr, en: b_en, mbox: b_mbox};

  assign a_oe = dcf_pkg::drive_out(ctl_a);
  assign b_oe = dcf_pkg::drive_out(ctl_b);

  // threshold offset, captured as reset releases
  logic [PW-1:0] x_val;
  always_ff @(posedge rst_n) x_val <= PW'(dcf_pkg::thresh_for(fs));

  // named internal events, also observed by the checker
  logic          wr_ok, rd_ok;
  logic [PW-1:0] wptr_bin, wptr_gray, rptr_bin, rptr_gray;
  logic [PW-1:0] rgray_at_w, wgray_at_r, wr_level;
  logic          wr_fire, rd_fire;

  dcf_sync #(.W(1), .STAGES(SYNC_STAGES)) u_wrst (
    .clk(clka), .rst_n(rst_n), .d(1'b1), .q(wr_ok));
  dcf_sync #(.W(1), .STAGES(SYNC_STAGES)) u_rrst (
    .clk(clkb), .rst_n(rst_n), .d(1'b1), .q(rd_ok));
  dcf_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_r2w (
    .clk(clka), .rst_n(rst_n), .d(rptr_gray), .q(rgray_at_w));
  dcf_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_w2r (
    .clk(clkb), .rst_n(rst_n), .d(wptr_gray), .q(wgray_at_r));

  dcf_wr_side #(.AW(AW)) u_wr (
    .clk(clka), .rst_n(rst_n), .ok(wr_ok), .x(x_val), .ctl(ctl_a),
    .rgray_s(rgray_at_w), .wbin(wptr_bin), .wgray(wptr_gray),
    .level(wr_level), .full_n(full_n), .afull_n(afull_n), .we(wr_fire));

  dcf_rd_side #(.AW(AW)) u_rd (
    .clk(clkb), .rst_n(rst_n), .ok(rd_ok), .x(x_val), .ctl(ctl_b),
    .wgray_s(wgray_at_r), .rbin(rptr_bin), .rgray(rptr_gray),
    .empty_n(empty_n), .aempty_n(aempty_n), .re(rd_fire));

  dcf_mem #(.DW(DW), .AW(AW)) u_mem (
    .clka(clka), .clkb(clkb), .rst_n(rst_n),
    .we(wr_fire), .waddr(wptr_bin[AW-1:0]), .wdata(a_din),
    .re(rd_fire), .raddr(rptr_bin[AW-1:0]), .rdata(b_dout));

endmodule

// File: rtl/dcfifo36_chk.sv
module dcfifo36_chk #(
  parameter int DW = 36,
  parameter int AW = 6,
  localparam int PW = AW + 1
) (
  input logic          clka,
  input logic          clkb,
  input logic          rst_n,
  input logic          a_cs_n,
  input logic          a_wr,
  input logic          a_en,
  input logic          a_mbox,
  input logic          b_cs_n,
  input logic          b_wr,
  input logic          b_en,
  input logic          b_mbox,
  input logic          full_n,
  input logic          afull_n,
  input logic          empty_n,
  input logic          aempty_n,
  input logic [DW-1:0] b_dout,
  input logic [PW-1:0] wptr,
  input logic [PW-1:0] rptr,
  input logic [PW-1:0] wr_level,
  input logic [PW-1:0] x_val,
  input logic          wr_ok
);

  localparam logic [PW-1:0] DEPTH_P = PW'(1 << AW);

  logic a_req, b_req;
  assign a_req = !a_cs_n && a_wr && a_en && !a_mbox;
  assign b_req = !b_cs_n && !b_wr && b_en && !b_mbox;

  p_reset_wflags_r1: assert property (@(posedge clka)
    (rst_n === 1'b0) |-> (!full_n && afull_n && wptr == '0));

  p_reset_rflags_r1: assert property (@(posedge clkb)
    (rst_n === 1'b0) |-> (!empty_n && !aempty_n && rptr == '0));

  p_offset_hold_r3: assert property (@(posedge clka) disable iff (!rst_n)
    $past(rst_n) |-> $stable(x_val));

  p_write_step_r4: assert property (@(posedge clka) disable iff (!rst_n)
    (a_req && full_n) |=> (wptr == PW'($past(wptr) + PW'(1))));

  p_no_write_r4: assert property (@(posedge clka) disable iff (!rst_n)
    !a_req |=> $stable(wptr));

  p_read_step_r5: assert property (@(posedge clkb) disable iff (!rst_n)
    (b_req && empty_n) |=> (rptr == PW'($past(rptr) + PW'(1))));

  p_no_read_r5: assert property (@(posedge clkb) disable iff (!rst_n)
    !b_req |=> ($stable(rptr) && $stable(b_dout)));

  p_full_blocks_r7: assert property (@(posedge clka) disable iff (!rst_n)
    !full_n |=> $stable(wptr));

  p_level_cap_r7: assert property (@(posedge clka) disable iff (!rst_n)
    wr_level <= DEPTH_P);

  p_empty_is_aempty_r9: assert property (@(posedge clkb) disable iff (!rst_n)
    !empty_n |-> !aempty_n);

  p_full_is_afull_r10: assert property (@(posedge clka) disable iff (!rst_n)
    (wr_ok && !full_n) |-> !afull_n);

  p_empty_holds_r12: assert property (@(posedge clkb) disable iff (!rst_n)
    !empty_n |=> ($stable(b_dout) && $stable(rptr)));

endmodule

bind dcfifo36 dcfifo36_chk #(.DW(DW), .AW(AW)) u_chk (
  .clka(clka), .clkb(clkb), .rst_n(rst_n),
  .a_cs_n(a_cs_n), .a_wr(a_wr), .a_en(a_en), .a_mbox(a_mbox),
  .b_cs_n(b_cs_n), .b_wr(b_wr), .b_en(b_en), .b_mbox(b_mbox),
  .full_n(full_n), .afull_n(afull_n), .empty_n(empty_n), .aempty_n(aempty_n),
  .b_dout(b_dout), .wptr(wptr_bin), .rptr(rptr_bin), .wr_level(wr_level),
  .x_val(x_val), .wr_ok(wr_ok));

// File: tb/dcfifo36_tb_top.sv
module dcfifo36_tb_top;

  localparam int DEPTH = 64;

  logic        clka = 0, clkb = 0, rst_n = 0;
  logic [1:0]  fs = 2'b00;
  logic        a_cs_n = 1, a_wr = 0, a_en = 0, a_mbox = 0;
  logic [35:0] a_din = '0;
  logic        b_cs_n = 1, b_wr = 0, b_en = 0, b_mbox = 0;
  logic        a_oe, full_n, afull_n, b_oe, empty_n, aempty_n;
  logic [35:0] b_dout;

  int nchk = 0, nerr = 0, cyc = 0;

  dcfifo36 dut_i (
    .clka(clka), .clkb(clkb), .rst_n(rst_n), .fs(fs),
    .a_cs_n(a_cs_n), .a_wr(a_wr), .a_en(a_en), .a_mbox(a_mbox), .a_din(a_din),
    .a_oe(a_oe), .full_n(full_n), .afull_n(afull_n),
    .b_cs_n(b_cs_n), .b_wr(b_wr), .b_en(b_en), .b_mbox(b_mbox),
    .b_dout(b_dout), .b_oe(b_oe), .empty_n(empty_n), .aempty_n(aempty_n));

  // 50 MHz write clock, read clock same rate shifted by 7 ns
  initial forever #10 clka = ~clka;
  initial begin
    #17;
    forever begin clkb = 1; #10; clkb = 0; #10; end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int exp_x(logic [1:0] s);
    case (s)
      2'b00: return 4;
      2'b01: return 8;
      2'b10: return 12;
      default: return 16;
    endcase
  endfunction

  // ---------------- reference model ----------------
  logic [35:0] mq[$];
  logic [35:0] mdout = '0;
  int wtot = 0, rtot = 0, rs1 = 0, rs2 = 0, ws1 = 0, ws2 = 0;
  int wcnt = 0, rcnt = 0, xm = 4;

  always @(posedge rst_n) xm = exp_x(fs);

  always @(posedge clka) begin
    bit e_ff, e_af, e_oe;
    if (!rst_n) begin
      wtot = 0; rs1 = 0; rs2 = 0; wcnt = 0; mq.delete();
    end else begin
      if (!a_cs_n && a_wr && a_en && !a_mbox && wcnt >= 2 && (wtot - rs2) < DEPTH) begin
        mq.push_back(a_din);
        wtot++;
      end
      rs2 = rs1; rs1 = rtot;
      if (wcnt < 2) wcnt++;
    end
    e_ff = (wcnt >= 2) && ((wtot - rs2) < DEPTH);
    e_af = !(wcnt >= 2) || ((wtot - rs2) < DEPTH - xm);
    e_oe = !a_cs_n && !a_wr;
    #2;
    chk("R7/R4 full_n", 64'(full_n), 64'(e_ff));
    chk("R10 afull_n", 64'(afull_n), 64'(e_af));
    chk("R6 a_oe", 64'(a_oe), 64'(e_oe));
  end

  always @(posedge clkb) begin
    bit e_ef, e_ae, e_oe;
    if (!rst_n) begin
      rtot = 0; ws1 = 0; ws2 = 0; rcnt = 0; mdout = '0; mq.delete();
    end else begin
      if (!b_cs_n && !b_wr && b_en && !b_mbox && rcnt >= 2 && (ws2 - rtot) > 0) begin
        mdout = mq.pop_front();
        rtot++;
      end
      ws2 = ws1; ws1 = wtot;
      if (rcnt < 2) rcnt++;
    end
    e_ef = (rcnt >= 2) && ((ws2 - rtot) > 0);
    e_ae = (rcnt >= 2) && ((ws2 - rtot) > xm);
    e_oe = !b_cs_n && !b_wr;
    #2;
    chk("R8 empty_n", 64'(empty_n), 64'(e_ef));
    chk("R9 aempty_n", 64'(aempty_n), 64'(e_ae));
    chk("R11/R5 b_dout", 64'(b_dout), 64'(mdout));
    chk("R6 b_oe", 64'(b_oe), 64'(e_oe));
  end

  // ---------------- watchdog ----------------
  always @(posedge clka) begin
    cyc++;
    if (cyc > 150000) begin
      nerr++; nchk++;
      $display("FAIL watchdog expired after %0d cycles", cyc);
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  // ---------------- drivers ----------------
  task automatic a_set(input logic cs_n, input logic wr, input logic en,
                       input logic mb, input logic [35:0] d);
    @(negedge clka);
    a_cs_n = cs_n; a_wr = wr; a_en = en; a_mbox = mb; a_din = d;
  endtask

  task automatic b_set(input logic cs_n, input logic wr, input logic en, input logic mb);
    @(negedge clkb);
    b_cs_n = cs_n; b_wr = wr; b_en = en; b_mbox = mb;
  endtask

  task automatic settle();
    repeat (6) @(posedge clkb);
    #2;
  endtask

  task automatic do_reset(input logic [1:0] sel);
    @(negedge clka);
    rst_n = 0; fs = sel;
    a_cs_n = 1; a_wr = 0; a_en = 0; a_mbox = 0;
    b_cs_n = 1; b_wr = 0; b_en = 0; b_mbox = 0;
    repeat (5) @(negedge clka);
    chk("R1 full_n in reset", 64'(full_n), 64'(0));
    chk("R1 afull_n in reset", 64'(afull_n), 64'(1));
    chk("R1 empty_n in reset", 64'(empty_n), 64'(0));
    chk("R1 aempty_n in reset", 64'(aempty_n), 64'(0));
    chk("R1 b_dout in reset", 64'(b_dout), 64'(0));
    rst_n = 1;
    @(posedge clka); #2;
    chk("R2 full_n after one edge", 64'(full_n), 64'(0));
    @(posedge clka); #2;
    chk("R2 full_n after two edges", 64'(full_n), 64'(1));
  endtask

  function automatic logic [35:0] pat(int c, int i);
    return {2'(c), 26'h2A5A5A5, 8'(i)};
  endfunction

  // ---------------- stimulus ----------------
  initial begin
    for (int c = 3; c >= 0; c--) begin
      int n, x;
      x = exp_x(2'(c));
      do_reset(2'(c));
      fs = ~2'(c);                      // R3: later select changes ignored
      repeat (3) @(posedge clkb);

      // R4: each single qualifier violation stores nothing
      a_set(1, 1, 1, 0, 36'h1);
      a_set(0, 0, 1, 0, 36'h2);
      a_set(0, 1, 0, 0, 36'h3);
      a_set(0, 1, 1, 1, 36'h4);
      a_set(1, 0, 0, 0, '0);
      settle();
      chk("R4 no store on bad qualifier", 64'(empty_n), 64'(0));

      // R8: first word, empty_n release timing on the read clock
      a_set(0, 1, 1, 0, pat(c, 0));
      @(posedge clka); #1;
      a_cs_n = 1; a_wr = 0;
      @(posedge clkb); #2;
      chk("R8 empty_n after one read edge", 64'(empty_n), 64'(0));
      @(posedge clkb); #2;
      chk("R8 empty_n after two read edges", 64'(empty_n), 64'(1));
      n = 1;

      // R3/R9: almost-empty boundary at X and X+1
      while (n < x) begin a_set(0, 1, 1, 0, pat(c, n)); n++; end
      a_set(1, 0, 0, 0, '0);
      settle();
      chk("R3/R9 aempty_n at X words", 64'(aempty_n), 64'(0));
      a_set(0, 1, 1, 0, pat(c, n)); n++;
      a_set(1, 0, 0, 0, '0);
      settle();
      chk("R3/R9 aempty_n at X+1 words", 64'(aempty_n), 64'(1));

      // R10: almost-full boundary
      while (n < DEPTH - x - 1) begin a_set(0, 1, 1, 0, pat(c, n)); n++; end
      a_set(1, 0, 0, 0, '0);
      settle();
      chk("R10 afull_n at 63-X words", 64'(afull_n), 64'(1));
      a_set(0, 1, 1, 0, pat(c, n)); n++;
      a_set(1, 0, 0, 0, '0);
      settle();
      chk("R10 afull_n at 64-X words", 64'(afull_n), 64'(0));

      // R7: fill, then extra writes dropped
      while (n < DEPTH) begin a_set(0, 1, 1, 0, pat(c, n)); n++; end
      a_set(0, 1, 1, 0, 36'hBAD);
      a_set(0, 1, 1, 0, 36'hBAD);
      a_set(1, 0, 0, 0, '0);
      settle();
      chk("R7 full_n at 64 words", 64'(full_n), 64'(0));

      // R5: bad read qualifiers move nothing
      b_set(1, 0, 1, 0);
      b_set(0, 1, 1, 0);
      b_set(0, 0, 0, 0);
      b_set(0, 0, 1, 1);
      b_set(1, 0, 0, 0);
      settle();
      chk("R5 b_dout unchanged", 64'(b_dout), 64'(0));
      chk("R5 still full", 64'(full_n), 64'(0));

      // R11: drain in order
      for (int i = 0; i < DEPTH; i++) begin
        b_set(0, 0, 1, 0);
        @(posedge clkb); #2;
        chk("R11 drain order", 64'(b_dout), 64'(pat(c, i)));
      end
      b_set(1, 0, 0, 0);
      settle();
      chk("R8 empty after drain", 64'(empty_n), 64'(0));

      // R12: reads on empty hold output
      repeat (3) b_set(0, 0, 1, 0);
      b_set(1, 0, 0, 0);
      settle();
      chk("R12 b_dout holds on empty", 64'(b_dout), 64'(pat(c, DEPTH - 1)));
    end

    // concurrent traffic with random qualifiers
    do_reset(2'b10);
    repeat (3) @(posedge clkb);
    fork
      begin
        for (int k = 0; k < 1500; k++) begin
          int r;
          r = $urandom_range(0, 9);
          a_set(r == 7, r != 8, r != 9, r == 6, 36'($urandom) ^ {4'(k), 32'h0});
        end
        a_set(1, 0, 0, 0, '0);
      end
      begin
        for (int k = 0; k < 1500; k++) begin
          int r;
          r = $urandom_range(0, 9);
          b_set(r == 7, r == 8, r != 9, r == 6);
        end
        b_set(1, 0, 0, 0);
      end
    join
    settle();

    // reset while holding data
    repeat (20) a_set(0, 1, 1, 0, 36'($urandom));
    a_set(1, 0, 0, 0, '0);
    do_reset(2'b01);
    settle();
    chk("R1 empty after mid-stream reset", 64'(empty_n), 64'(0));

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule